// File: doc/BRIEF.md
# Timer Compare-Capture Unit

A 16-bit free-running timer with three compare channels and four capture channels, all reached through a flat word-addressed register bus. While the timer runs, any compare channel whose value equals the count raises its match flag. It can also drive a dedicated output pin high or low. The first two compare channels can additionally flip one toggle pin each. The timer flags an overflow when it wraps from FFFFh to 0000h. A run bit stops the count without losing its value.

Each capture input passes through a two-stage synchronizer and an edge detector. When a channel has its rising and/or falling trigger enabled, the selected edge copies the current count into that channel's capture register and sets the channel's flag. When neither trigger is enabled, the pin is a plain external interrupt: a falling edge sets the flag and the capture register is left alone. A single interrupt line is high while any flag is set. Software clears flags by writing ones.

Register words (addr): 0 control (bit 0 = run), 1 timer count, 2..4 compare 0..2, 5 set/reset enables, 6 toggle control, 7 capture edge enables, 8 flags, 9..12 capture 0..3 (read only). Unused addresses read zero.

Top module: `tcc_unit`

## Requirements
- R1: After synchronous reset, the count, run bit, all enables, flags, capture registers, compare registers and output pins are zero, and irq is low.
- R2: With run (addr 0 bit 0) at 1, the count advances by one on every clock. A write to addr 1 loads the count and takes precedence over the increment in the same cycle.
- R3: When the timer advances from FFFFh to 0000h, flag bit 0 (overflow) is set on that same clock edge.
- R4: A match on compare channel i means run is 1 and the count equals compare register i (addr 2+i). A match sets flag bit 1+i on the next clock edge.
- R5: Output pin sr_out[i] goes high on the clock after a match on channel i if set-enable addr 5 bit i is 1. It goes low if reset-enable addr 5 bit 3+i is 1 and set-enable is 0. Set wins when both are enabled.
- R6: Toggle pin k (k = 0, 1) inverts on the clock after a match on compare channel k when addr 6 bit k is 1. Addr 6 bits 3:2 read the toggle pin states. A write to addr 6 loads them from wdata bits 3:2, and the write wins over a toggle in the same cycle.
- R7: Capture input j is synchronized by two flops before edge detection. With addr 7 bit j (rising) or bit 4+j (falling) enabled, the chosen edge copies the count into capture register j (addr 9+j) and sets flag bit 4+j. A pin change driven in the cycle that holds count T captures T+2 while running.
- R8: With both trigger enables of channel j cleared, a falling edge on that pin sets flag bit 4+j, a rising edge does nothing, and capture register j keeps its value.
- R9: Writing addr 8 clears each flag whose wdata bit is 1. A flag being set by hardware in the same cycle stays set. Without such a write, flags never clear.
- R10: irq is high exactly when at least one flag bit is set.
- R11: With run at 0, the count holds its value, no match occurs, and no output pin or match flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address (read and write) |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr, combinational |
| cap_in | input | 4 | Capture / external interrupt pins |
| sr_out | output | 3 | Set/reset compare outputs |
| tog_out | output | 2 | Toggle compare outputs |
| irq | output | 1 | Any flag set |

## Verification
On every cycle the assertions check counter stepping and holding, overflow flagging at the wrap, set-over-reset priority on compare channel 0, pin stability while halted, and that flags only disappear through a clear write. The bench covers what depends on longer sequences. A cycle model follows pins, toggles, flags and count through random compare, enable, run and clear traffic. Directed scenarios show edge selection per capture channel, the two-cycle synchronizer delay on a running timer, the plain-interrupt fallback, and a hardware set colliding with a software clear.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
    localparam int TW   = 16;
    localparam int NCMP = 3;
    localparam int NCAP = 4;
    localparam int NTOG = 2;
    localparam int AW   = 4;
    localparam int FW   = 1 + NCMP + NCAP;

    localparam int ADR_CTRL   = 0;
    localparam int ADR_TIMER  = 1;
    localparam int ADR_CMP0   = 2;
    localparam int ADR_SETRST = ADR_CMP0 + NCMP;
    localparam int ADR_TOGGLE = ADR_SETRST + 1;
    localparam int ADR_CAPCFG = ADR_TOGGLE + 1;
    localparam int ADR_FLAGS  = ADR_CAPCFG + 1;
    localparam int ADR_CAP0   = ADR_FLAGS + 1;

    typedef logic [TW-1:0] tval_t;

    typedef struct packed {
        logic [NCMP-1:0] rst_en;
        logic [NCMP-1:0] set_en;
    } srcfg_t;

    function automatic logic hit(input logic run, input tval_t c, input tval_t r);
        return run && (c == r);
    endfunction

    function automatic logic at_adr(input logic we, input logic [AW-1:0] a, input int adr);
        return we && (a == AW'(adr));
    endfunction
endpackage

// File: rtl/tcc_counter.sv
module tcc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         ovf_evt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (run)  cnt <= cnt + W'(1);
    end

    assign ovf_evt = run && !load && (cnt == TOP);
endmodule

// File: rtl/tcc_cap_ch.sv
module tcc_cap_ch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pin,
    input  logic         rise_en,
    input  logic         fall_en,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cap_val,
    output logic         evt
);
    logic [2:0] sync_q;
    logic       rise, fall, plain, trig;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], pin};
    end

    assign rise  = sync_q[1] & ~sync_q[2];
    assign fall  = ~sync_q[1] & sync_q[2];
    assign plain = !rise_en && !fall_en;
    assign trig  = (rise && rise_en) || (fall && fall_en);
    assign evt   = plain ? fall : trig;

    always_ff @(posedge clk) begin
        if (rst)       cap_val <= '0;
        else if (trig) cap_val <= cnt;
    end
endmodule

// File: rtl/tcc_cmp_out.sv
module tcc_cmp_out #(
    parameter int NM = 3,
    parameter int NT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NM-1:0] match,
    input  logic [NM-1:0] set_en,
    input  logic [NM-1:0] rst_en,
    input  logic [NT-1:0] tog_en,
    input  logic          tog_wr,
    input  logic [NT-1:0] tog_wval,
    output logic [NM-1:0] sr_out,
    output logic [NT-1:0] tog_out
);
    for (genvar g = 0; g < NM; g++) begin : g_sr
        always_ff @(posedge clk) begin
            if (rst)                          sr_out[g] <= 1'b0;
            else if (match[g] && set_en[g])   sr_out[g] <= 1'b1;
            else if (match[g] && rst_en[g])   sr_out[g] <= 1'b0;
        end
    end

    for (genvar k = 0; k < NT; k++) begin : g_tog
        always_ff @(posedge clk) begin
            if (rst)                          tog_out[k] <= 1'b0;
            else if (tog_wr)                  tog_out[k] <= tog_wval[k];
            else if (match[k] && tog_en[k])   tog_out[k] <= ~tog_out[k];
        end
    end
endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
    import tcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [TW-1:0]   wdata,
    output logic [TW-1:0]   rd_data,
    input  logic [NCAP-1:0] cap_in,
    output logic [NCMP-1:0] sr_out,
    output logic [NTOG-1:0] tog_out,
    output logic            irq
);
    logic            run;
    tval_t           cnt;
    tval_t           cmp_q [NCMP];
    tval_t           cap_q [NCAP];
    srcfg_t          srcfg;
    logic [NTOG-1:0] tog_en;
    logic [NCAP-1:0] rise_en, fall_en, cap_evt;
    logic [NCMP-1:0] match;
    logic            ovf_evt;
    logic [FW-1:0]   flags, set_v, clr_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            srcfg   <= '0;
            tog_en  <= '0;
            rise_en <= '0;
            fall_en <= '0;
            for (int i = 0; i < NCMP; i++) cmp_q[i] <= '0;
        end else begin
            if (at_adr(wr_en, addr, ADR_CTRL))   run    <= wdata[0];
            if (at_adr(wr_en, addr, ADR_SETRST)) srcfg  <= srcfg_t'(wdata[2*NCMP-1:0]);
            if (at_adr(wr_en, addr, ADR_TOGGLE)) tog_en <= wdata[NTOG-1:0];
            if (at_adr(wr_en, addr, ADR_CAPCFG)) begin
                rise_en <= wdata[NCAP-1:0];
                fall_en <= wdata[2*NCAP-1:NCAP];
            end
            for (int i = 0; i < NCMP; i++)
                if (at_adr(wr_en, addr, ADR_CMP0 + i)) cmp_q[i] <= wdata;
        end
    end

    tcc_counter #(.W(TW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .load     (at_adr(wr_en, addr, ADR_TIMER)),
        .load_val (wdata),
        .cnt      (cnt),
        .ovf_evt  (ovf_evt)
    );

    for (genvar g = 0; g < NCMP; g++) begin : g_match
        assign match[g] = hit(run, cnt, cmp_q[g]);
    end

    for (genvar g = 0; g < NCAP; g++) begin : g_cap
        tcc_cap_ch #(.W(TW)) u_cap (
            .clk     (clk),
            .rst     (rst),
            .pin     (cap_in[g]),
            .rise_en (rise_en[g]),
            .fall_en (fall_en[g]),
            .cnt     (cnt),
            .cap_val (cap_q[g]),
            .evt     (cap_evt[g])
        );
    end

    tcc_cmp_out #(.NM(NCMP), .NT(NTOG)) u_out (
        .clk      (clk),
        .rst      (rst),
        .match    (match),
        .set_en   (srcfg.set_en),
        .rst_en   (srcfg.rst_en),
        .tog_en   (tog_en),
        .tog_wr   (at_adr(wr_en, addr, ADR_TOGGLE)),
        .tog_wval (wdata[2*NTOG-1:NTOG]),
        .sr_out   (sr_out),
        .tog_out  (tog_out)
    );

    assign set_v = {cap_evt, match, ovf_evt};
    assign clr_v = at_adr(wr_en, addr, ADR_FLAGS) ? wdata[FW-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_v) | set_v;
    end

    assign irq = |flags;

    always_comb begin
        rd_data = '0;
        if (addr == AW'(ADR_CTRL))   rd_data[0] = run;
        if (addr == AW'(ADR_TIMER))  rd_data = cnt;
        if (addr == AW'(ADR_SETRST)) rd_data[2*NCMP-1:0] = srcfg;
        if (addr == AW'(ADR_TOGGLE)) rd_data[2*NTOG-1:0] = {tog_out, tog_en};
        if (addr == AW'(ADR_CAPCFG)) rd_data[2*NCAP-1:0] = {fall_en, rise_en};
        if (addr == AW'(ADR_FLAGS))  rd_data[FW-1:0] = flags;
        for (int i = 0; i < NCMP; i++)
            if (addr == AW'(ADR_CMP0 + i)) rd_data = cmp_q[i];
        for (int i = 0; i < NCAP; i++)
            if (addr == AW'(ADR_CAP0 + i)) rd_data = cap_q[i];
    end
endmodule

// File: rtl/tcc_unit_chk.sv
module tcc_unit_chk
    import tcc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [AW-1:0]   addr,
    input logic            run,
    input tval_t           cnt,
    input tval_t           cmp0,
    input logic            set0,
    input logic            rst0,
    input logic [NCMP-1:0] sr_out,
    input logic [FW-1:0]   flags
);
    logic ld_cnt, clr_wr;
    assign ld_cnt = wr_en && (addr == AW'(ADR_TIMER));
    assign clr_wr = wr_en && (addr == AW'(ADR_FLAGS));

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !ld_cnt) |=> (cnt == TW'($past(cnt) + 1))); // R2
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !ld_cnt) |=> $stable(cnt)); // R11
    AST_HALT_PINS: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(sr_out)); // R11
    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (run && !ld_cnt && cnt == '1) |=> flags[0]); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == cmp0 && set0) |=> sr_out[0]); // R5
    AST_RESET_ONLY: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == cmp0 && !set0 && rst0) |=> !sr_out[0]); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((flags & $past(flags)) == $past(flags))); // R9
endmodule

bind tcc_unit tcc_unit_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .run    (run),
    .cnt    (cnt),
    .cmp0   (cmp_q[0]),
    .set0   (srcfg.set_en[0]),
    .rst0   (srcfg.rst_en[0]),
    .sr_out (sr_out),
    .flags  (flags)
);

// File: tb/tcc_unit_tb_top.sv
module tcc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rd_data;
    logic [3:0]  cap_in = 4'd0;
    logic [2:0]  sr_out;
    logic [1:0]  tog_out;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tcc_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .cap_in(cap_in), .sr_out(sr_out),
        .tog_out(tog_out), .irq(irq)
    );

    // bench model of the requirement-level state
    logic [15:0] m_cnt, m_cmp [3];
    logic        m_run;
    logic [5:0]  m_setrst;
    logic [1:0]  m_togen, m_tog;
    logic [2:0]  m_sr;
    logic [7:0]  m_flags;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic wn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic we, input logic [3:0] a, input logic [15:0] d);
        logic [2:0]  mt;
        logic [2:0]  n_sr;
        logic [1:0]  n_tog;
        logic [15:0] n_cnt;
        logic        ovf;
        logic [7:0]  clr;
        for (int i = 0; i < 3; i++) mt[i] = m_run && (m_cnt == m_cmp[i]);
        for (int i = 0; i < 3; i++)
            n_sr[i] = (mt[i] && m_setrst[i]) ? 1'b1 : (mt[i] && m_setrst[3+i]) ? 1'b0 : m_sr[i];
        for (int k = 0; k < 2; k++)
            n_tog[k] = (we && a == 4'd6) ? d[2+k] : (mt[k] && m_togen[k]) ? ~m_tog[k] : m_tog[k];
        ovf   = m_run && !(we && a == 4'd1) && (m_cnt == 16'hFFFF);
        n_cnt = (we && a == 4'd1) ? d : m_run ? m_cnt + 16'd1 : m_cnt;
        clr   = (we && a == 4'd8) ? d[7:0] : 8'd0;
        wr_en = we; addr = a; wdata = d;
        @(negedge clk);
        m_flags = (m_flags & ~clr) | {4'd0, mt, ovf};
        m_sr = n_sr; m_tog = n_tog; m_cnt = n_cnt;
        if (we && a == 4'd0) m_run = d[0];
        if (we && a == 4'd5) m_setrst = d[5:0];
        if (we && a == 4'd6) m_togen = d[1:0];
        for (int i = 0; i < 3; i++) if (we && a == 4'(2 + i)) m_cmp[i] = d;
        chk(sr_out == m_sr, "R5 set/reset pins", {13'd0, sr_out}, {13'd0, m_sr});
        chk(tog_out == m_tog, "R6 toggle pins", {14'd0, tog_out}, {14'd0, m_tog});
        chk(irq == (m_flags != 0), "R10 irq", {15'd0, irq}, {15'd0, m_flags != 0});
        if (!we && a == 4'd1) chk(rd_data == m_cnt, "R2 count", rd_data, m_cnt);
        if (!we && a == 4'd8) chk(rd_data[7:0] == m_flags, "R3/R4/R9 flags", rd_data, {8'd0, m_flags});
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [2:0]  p;
        int          act;
        void'($urandom(32'd1357));
        wn(3);
        rst = 1'b0;
        // R1: reset state
        rd(4'd1, v);  chk(v == 0, "R1 count", v, 0);
        rd(4'd0, v);  chk(v == 0, "R1 run", v, 0);
        rd(4'd8, v);  chk(v == 0, "R1 flags", v, 0);
        rd(4'd9, v);  chk(v == 0, "R1 capture", v, 0);
        chk(sr_out == 0 && tog_out == 0 && irq == 0, "R1 pins/irq", {11'd0, sr_out, tog_out, irq}, 0);

        // random phase against the bench model
        m_cnt = 0; m_run = 0; m_setrst = 0; m_togen = 0; m_tog = 0; m_sr = 0; m_flags = 0;
        for (int i = 0; i < 3; i++) m_cmp[i] = 0;
        drive(1'b1, 4'd1, 16'hFFF0);
        drive(1'b1, 4'd2, 16'hFFF4);
        drive(1'b1, 4'd3, 16'hFFF6);
        drive(1'b1, 4'd4, 16'hFFF9);
        drive(1'b1, 4'd5, 16'h0027);
        drive(1'b1, 4'd6, 16'h0003);
        drive(1'b1, 4'd0, 16'h0001);
        for (int n = 0; n < 3000; n++) begin
            act = $urandom % 16;
            case (act)
                0, 1: drive(1'b1, 4'(2 + $urandom % 3), m_cnt + 16'(1 + $urandom % 6));
                2:    drive(1'b1, 4'd5, 16'($urandom % 64));
                3:    drive(1'b1, 4'd6, 16'($urandom % 16));
                4:    drive(1'b1, 4'd0, 16'(($urandom % 4) != 0));
                5:    drive(1'b1, 4'd8, 16'($urandom % 256));
                6:    drive(1'b1, 4'd1, 16'hFFF8 + 16'($urandom % 8));
                default: drive(1'b0, (n % 2) ? 4'd1 : 4'd8, 16'd0);
            endcase
        end

        // R11: halted timer keeps value, no matches
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'h0500);
        wr(4'd2, 16'h0500);
        wr(4'd3, 16'h9999);
        wr(4'd4, 16'h9999);
        wr(4'd5, 16'h0007);
        wr(4'd6, 16'h0003);
        wr(4'd8, 16'h00FF);
        p = sr_out;
        wn(6);
        rd(4'd1, v); chk(v == 16'h0500, "R11 count held", v, 16'h0500);
        chk(sr_out == p && tog_out == 0, "R11 pins unchanged", {11'd0, sr_out, tog_out}, {11'd0, p, 2'b00});
        rd(4'd8, v); chk(v == 0, "R11 no match flag", v, 0);
        // R4/R5/R6: start; match occurs in the cycle after run rises
        wr(4'd0, 16'h0001);
        chk(sr_out == p, "R5 pin before match", {13'd0, sr_out}, {13'd0, p});
        wn(1);
        chk(sr_out == {p[2:1], 1'b1}, "R5 pin set one clock after match", {13'd0, sr_out}, {13'd0, p[2:1], 1'b1});
        chk(tog_out == 2'b01, "R6 toggle on match", {14'd0, tog_out}, 16'd1);
        rd(4'd8, v); chk(v[3:0] == 4'b0010, "R4 match flag", v, 16'h0002);
        rd(4'd6, v); chk(v[3:0] == 4'b0111, "R6 toggle readback", v, 16'h0007);

        // R7/R8: captures on a halted timer
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'h1234);
        wr(4'd7, 16'h0065);
        wr(4'd8, 16'h00FF);
        cap_in[0] = 1'b1; wn(4);
        rd(4'd9, v); chk(v == 16'h1234, "R7 rising capture ch0", v, 16'h1234);
        rd(4'd8, v); chk(v[4] == 1'b1, "R7 ch0 flag", v, 16'h0010);
        cap_in[1] = 1'b1; wn(4);
        rd(4'd10, v); chk(v == 0, "R7 ch1 ignores rising edge", v, 0);
        rd(4'd8, v); chk(v[5] == 1'b0, "R7 ch1 flag stays clear", v, 16'h0010);
        wr(4'd1, 16'h2000);
        cap_in[1] = 1'b0; wn(4);
        rd(4'd10, v); chk(v == 16'h2000, "R7 falling capture ch1", v, 16'h2000);
        cap_in[3] = 1'b1; wn(4);
        rd(4'd8, v); chk(v[7] == 1'b0, "R8 rising edge no flag", v, 16'h0030);
        cap_in[3] = 1'b0; wn(4);
        rd(4'd8, v); chk(v[7] == 1'b1, "R8 falling edge flag", v, 16'h00B0);
        rd(4'd12, v); chk(v == 0, "R8 capture register unchanged", v, 0);
        chk(irq == 1'b1, "R10 irq with flags", {15'd0, irq}, 1);
        // R7 timing on a running timer
        wr(4'd0, 16'h0001);
        wr(4'd1, 16'h4000);
        cap_in[2] = 1'b1; wn(5);
        wr(4'd0, 16'h0000);
        rd(4'd11, v); chk(v == 16'h4002, "R7 sync delay capture ch2", v, 16'h4002);

        // R9: hardware set beats clear in the same cycle
        wr(4'd8, 16'h00FF);
        cap_in[3] = 1'b1; wn(4);
        cap_in[3] = 1'b0; wn(2);
        wr(4'd8, 16'h0080);
        rd(4'd8, v); chk(v[7] == 1'b1, "R9 set wins over clear", v, 16'h0080);
        wr(4'd8, 16'h00FF);
        rd(4'd8, v); chk(v == 0, "R9 clear by writing ones", v, 0);
        chk(irq == 1'b0, "R10 irq low when flags clear", {15'd0, irq}, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule